// File: doc/BRIEF.md
# Fractional-Ratio Shift Clock Generator

This block makes the master shift clock for a serial shifter. It runs entirely on one system clock. Three reference strobes arrive from outside at rates set elsewhere. Each strobe is a single-cycle pulse, and each pulse stands for one edge of a reference clock, so one reference period spans two strobes. A select field picks one reference, or a reserved code picks none and gates the clock off. The chosen strobe stream then receives one of four treatments:

- direct,
- inverted,
- divide by 1.5,
- divide by 2.5.

The block drives a shift-clock level on the clock output pin. Alongside it come two single-cycle strobes that tell the shifter when to capture the incoming bit and when to launch the next one. Both strobes fall in exactly the cycle in which the pin changes level.

A frame runs while `run` is high. Outside a frame the pin rests at a configured idle level. When `run` falls in the middle of the active half of a period, that half is finished first, so no runt pulse appears. The source, treatment and idle level are taken in only while no frame is running and the pin is at rest. A change made during a frame therefore waits for the next idle gap.

Top module: `sclk_gen`

## Requirements
- R1: After reset, `sck_out` is 0 and both `sample_stb` and `shift_stb` are 0.
- R2: Select code 0, 1 or 2 on `src_sel` routes `ref_stb[0]`, `ref_stb[1]` or `ref_stb[2]` as the step source. Code 3 is reserved: `sck_out` stays at the idle level and no strobe is issued even while `run` is high.
- R3: Treatment code 00 (direct): the active half lasts 1 source strobe and the rest half lasts 1. `sample_stb` marks the leading edge (leaving the idle level) and `shift_stb` marks the trailing edge.
- R4: Treatment code 01 (inverted): the half lengths are the same as for direct, but `sample_stb` marks the trailing edge and `shift_stb` marks the leading edge.
- R5: Treatment code 10 (divide by 1.5): the active half lasts 2 source strobes and the rest half lasts 1. This gives a uniform period of 3 strobes, which is 1.5 reference periods.
- R6: Treatment code 11 (divide by 2.5): the active half lasts 3 source strobes and the rest half lasts 2. This gives a uniform period of 5 strobes, which is 2.5 reference periods.
- R7: Each strobe is one system cycle long and appears only in the cycle in which `sck_out` changes level. The two strobes never appear together.
- R8: While `run` is low and the clock is at rest, `sck_out` equals the captured idle level. If `run` falls during an active half, that half still runs to its full length before the pin returns to rest.
- R9: `src_sel`, `treat_sel` and `idle_lvl` are captured only in cycles where `run` is low and the clock is at rest. A change at any other time has no effect on the running waveform.
- R10: A source strobe that is high in every cycle gives the fastest clock: in direct mode `sck_out` toggles every system cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_stb | input | 3 | Reference edge strobes, one per source |
| src_sel | input | 2 | Source select (3 = clock off) |
| treat_sel | input | 2 | Treatment: 00 direct, 01 inverted, 10 /1.5, 11 /2.5 |
| idle_lvl | input | 1 | Level of the pin at rest |
| run | input | 1 | Frame in progress |
| sck_out | output | 1 | Shift clock level for the clock pin |
| sample_stb | output | 1 | Capture strobe for the shifter |
| shift_stb | output | 1 | Launch strobe for the shifter |

## Verification
A stuck or overrunning half-period counter shows at the pin as a wrong half length, and this becomes visible at the very next edge: within at most three source strobes. An edge-sense error swaps or drops a strobe at the first leading or trailing edge of a frame. A configuration register that loads at the wrong moment shows as a mid-frame change of half length or of idle level, visible one strobe after the disallowed write. A stop that is handled wrongly leaves the pin away from rest, or cuts an active half short, once `run` falls.

// File: rtl/sclk_pkg.sv
package sclk_pkg;

  localparam int CNT_W = 2;

  typedef enum logic [1:0] {
    TR_DIRECT = 2'b00,
    TR_INVERT = 2'b01,
    TR_DIV15  = 2'b10,
    TR_DIV25  = 2'b11
  } treat_e;

  typedef struct packed {
    treat_e treat;
    logic   idle;
  } shape_t;

  // Number of source strobes that one half of the output period spans.
  // away_half = 1 selects the half spent away from the idle level.
  function automatic logic [CNT_W-1:0] half_len(treat_e t, logic away_half);
    logic [CNT_W-1:0] n;
    unique case (t)
      TR_DIV15: n = away_half ? 2'd2 : 2'd1;
      TR_DIV25: n = away_half ? 2'd3 : 2'd2;
      default:  n = 2'd1;
    endcase
    return n;
  endfunction

  // Whether the capture strobe rides on the leading edge.
  function automatic logic sample_on_lead(treat_e t);
    return t != TR_INVERT;
  endfunction

endpackage

// File: rtl/sclk_cfg_hold.sv
module sclk_cfg_hold
  import sclk_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [SEL_W-1:0] src_in,
  input  logic [1:0]       treat_in,
  input  logic             idle_in,
  output logic [SEL_W-1:0] src_q,
  output shape_t           shape_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q         <= '0;
      shape_q.treat <= TR_DIRECT;
      shape_q.idle  <= 1'b0;
    end else if (capture) begin
      src_q         <= src_in;
      shape_q.treat <= treat_e'(treat_in);
      shape_q.idle  <= idle_in;
    end
  end

  // R9
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> ($stable(src_q) && $stable(shape_q)));

endmodule

// File: rtl/sclk_src_mux.sv
module sclk_src_mux #(
  parameter int N_REF = 3,
  parameter int SEL_W = 2
) (
  input  logic [N_REF-1:0] ref_stb,
  input  logic [SEL_W-1:0] src_q,
  output logic             step_stb
);

  logic [N_REF-1:0] hit;

  for (genvar i = 0; i < N_REF; i++) begin : g_src
    assign hit[i] = ref_stb[i] && (src_q == SEL_W'(i));
  end

  assign step_stb = |hit;

endmodule

// File: rtl/sclk_phase_gen.sv
module sclk_phase_gen
  import sclk_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   run,
  input  logic   step_stb,
  input  shape_t shape_q,
  output logic   away,
  output logic   sample_stb,
  output logic   shift_stb
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_inc;
  logic [CNT_W-1:0] len_now;
  logic             live;
  logic             step;
  logic             flip;
  logic             lead_next;
  logic             lead_samples;

  assign live         = run || away;
  assign step         = live && step_stb;
  assign cnt_inc      = cnt + 1'b1;
  assign len_now      = half_len(shape_q.treat, away);
  assign flip         = step && (cnt_inc == len_now);
  assign lead_next    = !away;
  assign lead_samples = sample_on_lead(shape_q.treat);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      away       <= 1'b0;
      cnt        <= '0;
      sample_stb <= 1'b0;
      shift_stb  <= 1'b0;
    end else begin
      sample_stb <= flip && (lead_next == lead_samples);
      shift_stb  <= flip && (lead_next != lead_samples);
      if (flip) begin
        away <= !away;
        cnt  <= '0;
      end else if (step) begin
        cnt <= cnt_inc;
      end else if (!live) begin
        cnt <= '0;
      end
    end
  end

  // R5
  cnt_in_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < len_now);

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_stb && shift_stb));

  // R7
  strobe_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb || shift_stb) |-> (away != $past(away)));

  // R8
  rest_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !away) |=> !away);

endmodule

// File: rtl/sclk_gen.sv
module sclk_gen
  import sclk_pkg::*;
#(
  parameter int N_REF = 3,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_REF-1:0] ref_stb,
  input  logic [SEL_W-1:0] src_sel,
  input  logic [1:0]       treat_sel,
  input  logic             idle_lvl,
  input  logic             run,
  output logic             sck_out,
  output logic             sample_stb,
  output logic             shift_stb
);

  localparam logic [SEL_W-1:0] SRC_OFF = SEL_W'(N_REF);

  logic [SEL_W-1:0] src_q;
  shape_t           shape_q;
  logic             step_stb;
  logic             away_w;
  logic             capture_w;

  assign capture_w = !run && !away_w;

  sclk_cfg_hold #(.SEL_W(SEL_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (capture_w),
    .src_in   (src_sel),
    .treat_in (treat_sel),
    .idle_in  (idle_lvl),
    .src_q    (src_q),
    .shape_q  (shape_q)
  );

  sclk_src_mux #(.N_REF(N_REF), .SEL_W(SEL_W)) u_mux (
    .ref_stb  (ref_stb),
    .src_q    (src_q),
    .step_stb (step_stb)
  );

  sclk_phase_gen u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .step_stb   (step_stb),
    .shape_q    (shape_q),
    .away       (away_w),
    .sample_stb (sample_stb),
    .shift_stb  (shift_stb)
  );

  assign sck_out = away_w ^ shape_q.idle;

  // R2
  gated_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_q == SRC_OFF) |-> !away_w);

  // R9
  away_no_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    away_w |=> $stable(shape_q.idle));

endmodule

// File: tb/sclk_gen_test.sv
module sclk_gen_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] ref_stb = 3'b000;
  logic [1:0] src_sel = 2'd0;
  logic [1:0] treat_sel = 2'd0;
  logic       idle_lvl = 1'b0;
  logic       run = 1'b0;
  logic       sck_out;
  logic       sample_stb;
  logic       shift_stb;

  always #4 clk = ~clk;

  sclk_gen uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_stb    (ref_stb),
    .src_sel    (src_sel),
    .treat_sel  (treat_sel),
    .idle_lvl   (idle_lvl),
    .run        (run),
    .sck_out    (sck_out),
    .sample_stb (sample_stb),
    .shift_stb  (shift_stb)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference strobe sources: every cycle, every 3rd, every 4th.
  int bcyc = 0;
  always @(posedge clk) begin
    #2;
    bcyc++;
    ref_stb <= {(bcyc % 4) == 0, (bcyc % 3) == 0, 1'b1};
  end

  function automatic int src_period(input int s);
    case (s)
      0: return 1;
      1: return 3;
      default: return 4;
    endcase
  endfunction

  // Edge monitor.
  bit mon_on = 0;
  bit exp_idle = 0;
  bit exp_inv = 0;
  logic prev_sck = 1'b0;
  int since_edge = 0;
  int away_len = 0;
  int rest_len = 0;
  int edges = 0;
  int strobe_err = 0;

  always @(negedge clk) begin
    if (mon_on) begin
      bit edge_seen;
      bit lead;
      bit want_sample;
      bit want_shift;
      since_edge++;
      edge_seen = (sck_out !== prev_sck);
      lead = edge_seen && (sck_out !== exp_idle);
      want_sample = edge_seen && (exp_inv ? !lead : lead);
      want_shift  = edge_seen && (exp_inv ? lead : !lead);
      if (edge_seen) begin
        if (lead) rest_len = since_edge;
        else      away_len = since_edge;
        since_edge = 0;
        edges++;
      end
      if (sample_stb !== want_sample || shift_stb !== want_shift) strobe_err++;
    end
    prev_sck = sck_out;
  end

  task automatic mon_start(input bit idle, input bit inv);
    exp_idle = idle;
    exp_inv = inv;
    since_edge = 0;
    away_len = 0;
    rest_len = 0;
    edges = 0;
    strobe_err = 0;
    mon_on = 1;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic setup(input int s, input int t, input bit idle);
    mon_on = 0;
    run = 1'b0;
    src_sel = 2'(s);
    treat_sel = 2'(t);
    idle_lvl = idle;
    step(4);
  endtask

  // {src, treat, idle, away strobes, rest strobes}
  localparam logic [8:0] VEC [8] = '{
    {2'd0, 2'd0, 1'b0, 2'd1, 2'd1},   // R3 R10
    {2'd1, 2'd1, 1'b1, 2'd1, 2'd1},   // R4
    {2'd2, 2'd2, 1'b0, 2'd2, 2'd1},   // R5
    {2'd1, 2'd3, 1'b0, 2'd3, 2'd2},   // R6
    {2'd0, 2'd3, 1'b1, 2'd3, 2'd2},   // R6
    {2'd2, 2'd0, 1'b1, 2'd1, 2'd1},   // R3
    {2'd0, 2'd2, 1'b0, 2'd2, 2'd1},   // R5
    {2'd3, 2'd0, 1'b0, 2'd0, 2'd0}    // R2 gated
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R1..: run hung actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    step(3);
    // R1: reset state
    chk(sck_out === 1'b0, "R1 sck_out at reset", int'(sck_out), 0);
    chk(sample_stb === 1'b0 && shift_stb === 1'b0, "R1 strobes at reset",
        int'({sample_stb, shift_stb}), 0);
    rst_n = 1'b1;
    step(2);

    foreach (VEC[i]) begin
      int s, t, a, b, p;
      bit idle;
      string tag;
      s = int'(VEC[i][8:7]);
      t = int'(VEC[i][6:5]);
      idle = VEC[i][4];
      a = int'(VEC[i][3:2]);
      b = int'(VEC[i][1:0]);
      p = src_period(s);
      tag = (t == 0) ? "R3" : (t == 1) ? "R4" : (t == 2) ? "R5" : "R6";
      setup(s, t, idle);
      // R8: resting at idle level while run is low with strobes present
      chk(sck_out === idle, "R8 rest level before frame", int'(sck_out), int'(idle));
      mon_start(idle, t == 1);
      run = 1'b1;
      step(80);
      if (s == 3) begin
        chk(edges == 0, "R2 gated source edges", edges, 0);
        chk(sck_out === idle, "R2 gated source level", int'(sck_out), int'(idle));
      end else begin
        chk(edges > 4, {tag, " edges present (R2 routing)"}, edges, 5);
        chk(away_len == a * p, {tag, " active half cycles"}, away_len, a * p);
        chk(rest_len == b * p, {tag, " rest half cycles"}, rest_len, b * p);
      end
      chk(strobe_err == 0, "R7 strobe placement", strobe_err, 0);
      run = 1'b0;
      step(20);
      chk(sck_out === idle, "R8 rest after frame", int'(sck_out), int'(idle));
    end

    // R8: run drops during an active half; the half completes.
    setup(2, 3, 1'b0);
    mon_start(1'b0, 1'b0);
    run = 1'b1;
    @(negedge clk);
    while (sck_out !== 1'b1) @(negedge clk);
    @(posedge clk);
    #2 run = 1'b0;
    step(30);
    chk(away_len == 12, "R8 active half completes after stop", away_len, 12);
    chk(sck_out === 1'b0, "R8 rest after stop", int'(sck_out), 0);
    begin
      int e0;
      e0 = edges;
      step(20);
      chk(edges == e0, "R8 no edges while stopped", edges, e0);
    end
    chk(strobe_err == 0, "R7 strobes around stop", strobe_err, 0);

    // R9: configuration writes during a frame are ignored.
    setup(0, 0, 1'b0);
    mon_start(1'b0, 1'b0);
    run = 1'b1;
    step(10);
    treat_sel = 2'd3;
    idle_lvl = 1'b1;
    src_sel = 2'd3;
    step(30);
    chk(edges > 20, "R9 clock keeps running", edges, 21);
    chk(away_len == 1 && rest_len == 1, "R9 half lengths unchanged",
        away_len * 10 + rest_len, 11);
    chk(strobe_err == 0, "R9 strobe sense unchanged", strobe_err, 0);
    mon_on = 0;
    run = 1'b0;
    step(6);
    chk(sck_out === 1'b1, "R9 new idle level taken at rest", int'(sck_out), 1);

    // R10: full-rate toggling, cycle by cycle
    setup(0, 0, 1'b0);
    mon_start(1'b0, 1'b0);
    run = 1'b1;
    step(4);
    begin
      int e0;
      e0 = edges;
      step(10);
      chk(edges - e0 == 10, "R10 toggle every cycle", edges - e0, 10);
    end
    run = 1'b0;
    step(5);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule